// File: doc/BRIEF.md
# Memory Bank Chip-Select Decoder

This block turns a 16-bit processor address and a memory/I-O cycle qualifier into four active-low chip selects for four 1K x 8 static RAM banks. It supports two mapping schemes, chosen by a mode input. In the first, each of four mid-order address bits acts directly as the select of one bank. This costs no decode logic, but the scheme can select several banks at once and it wastes address space. In the second, a 3-to-8 decoder is gated by the top address bits, so that each bank has exactly one 1K window in the lowest 4K of the map.

Besides the selects, the block forwards the low ten address bits and the read/write line to every bank. It raises three flags. The first marks a bus conflict, where more than one bank is selected. The second marks an unmapped memory access, where no bank is selected. The third marks an aliased access in direct-select mode, where the address differs from its canonical copy only in the ignored top bits. All outputs are registered and follow their inputs by one clock.

Top module: `memsel_top`

## Requirements
- R1: While rst is high, and on the first clock after it, sel_n is 4'b1111 and conflict, unmapped and alias_hit are 0.
- R2: When mem_cycle is 0 (an I/O cycle), sel_n is 4'b1111 and all three flags are 0, in either mode.
- R3: With full_mode=0 on a memory cycle, sel_n[i] equals addr[10+i] for i = 0..3. sel_n[0] is bank I and sel_n[3] is bank IV.
- R4: With full_mode=0 on a memory cycle, conflict is 1 exactly when two or more of addr[13:10] are 0.
- R5: With full_mode=0, addr[15:14] has no effect on sel_n. alias_hit is 1 exactly on a memory cycle where addr[15:14] is not 0 and at least one bank is selected. For example, 0x3800 and 0xB800 both select bank I, and only 0xB800 raises alias_hit.
- R6: With full_mode=1 on a memory cycle, a bank is selected only when addr[15:13] is 0. In that case bank i (sel_n[i]=0) is chosen when addr[12:10] equals i, which places banks I..IV at 0x0000, 0x0400, 0x0800 and 0x0C00.
- R7: unmapped is 1 exactly on a memory cycle where sel_n is 4'b1111. In full mode this includes addr[12:10] values 4 to 7.
- R8: With full_mode=1, at most one bit of sel_n is 0, and conflict and alias_hit stay 0.
- R9: rw_out carries rw_in to every bank, replicated on all four bits. bank_addr carries addr[9:0].
- R10: Each output reflects the inputs sampled at the previous rising clock edge. A change of input is not visible before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | Processor address |
| mem_cycle | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| full_mode | input | 1 | 0 = direct bit select, 1 = gated decoder |
| rw_in | input | 1 | Read/write line from the processor |
| sel_n | output | 4 | Active-low bank selects, bit i = bank i |
| rw_out | output | 4 | Read/write line, one copy per bank |
| bank_addr | output | 10 | In-bank address sent to all banks |
| conflict | output | 1 | More than one bank selected |
| unmapped | output | 1 | Memory cycle with no bank selected |
| alias_hit | output | 1 | Direct-select access through ignored top bits |

## Verification
The bench builds the block with its default parameters: a 16-bit address, four banks of 1K and a 3-bit decoder index. With these values the whole address space can be reached by random stimulus. Every pattern of bits 13..10 is hit, so the counts of zero bits that drive the conflict flag all occur. Every combination of the gating bits and the decoder index is also hit, including indices 4 to 7, which fall through to the unmapped flag. Directed cases cover the mirrored pair 0x3800/0xB800, each bank boundary in full mode, and the one-clock latency.

// File: rtl/memsel_pkg.sv
package memsel_pkg;
  typedef enum logic {
    MAP_DIRECT = 1'b0,
    MAP_GATED  = 1'b1
  } map_mode_e;

  // count of zero bits in a select vector (active-low selects)
  function automatic int unsigned count_low(input logic [31:0] v, input int unsigned w);
    int unsigned n;
    n = 0;
    for (int unsigned k = 0; k < w; k++) begin
      if (!v[k]) n++;
    end
    return n;
  endfunction
endpackage

// File: rtl/memsel_direct.sv
module memsel_direct #(
  parameter int BANKS  = 4,
  parameter int HIGH_W = 2
) (
  input  logic              mem_cycle,
  input  logic [BANKS-1:0]  sel_bits,
  input  logic [HIGH_W-1:0] high_bits,
  output logic [BANKS-1:0]  sel_n,
  output logic              conflict,
  output logic              unmapped,
  output logic              alias_hit
);
  logic [BANKS-1:0] low_vec;
  logic [$clog2(BANKS+1)-1:0] n_low;

  genvar i;
  generate
    for (i = 0; i < BANKS; i++) begin : g_bit
      assign low_vec[i] = mem_cycle & ~sel_bits[i];
    end
  endgenerate

  always_comb begin
    n_low = '0;
    for (int k = 0; k < BANKS; k++) begin
      n_low = n_low + {{($clog2(BANKS+1)-1){1'b0}}, low_vec[k]};
    end
  end

  assign sel_n     = ~low_vec;
  assign conflict  = (n_low > 1);
  assign unmapped  = mem_cycle & (n_low == 0);
  assign alias_hit = (n_low != 0) & (|high_bits);
endmodule

// File: rtl/memsel_gated.sv
module memsel_gated #(
  parameter int BANKS  = 4,
  parameter int DEC_W  = 3,
  parameter int GATE_W = 3
) (
  input  logic              mem_cycle,
  input  logic [DEC_W-1:0]  index,
  input  logic [GATE_W-1:0] gate_bits,
  output logic [BANKS-1:0]  sel_n,
  output logic              unmapped
);
  localparam int OUTS = 1 << DEC_W;
  logic            dec_en;
  logic [OUTS-1:0] dec_out;

  assign dec_en = mem_cycle & (gate_bits == '0);

  genvar j;
  generate
    for (j = 0; j < OUTS; j++) begin : g_dec
      assign dec_out[j] = dec_en & (index == DEC_W'(j));
    end
    for (j = 0; j < BANKS; j++) begin : g_sel
      assign sel_n[j] = ~dec_out[j];
    end
  endgenerate

  assign unmapped = mem_cycle & ~(|dec_out[BANKS-1:0]);
endmodule

// File: rtl/memsel_top.sv
module memsel_top #(
  parameter int ADDR_W  = 16,
  parameter int BANK_AW = 10,
  parameter int BANKS   = 4,
  parameter int DEC_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               mem_cycle,
  input  logic               full_mode,
  input  logic               rw_in,
  output logic [BANKS-1:0]   sel_n,
  output logic [BANKS-1:0]   rw_out,
  output logic [BANK_AW-1:0] bank_addr,
  output logic               conflict,
  output logic               unmapped,
  output logic               alias_hit
);
  import memsel_pkg::*;

  localparam int HIGH_W = ADDR_W - BANK_AW - BANKS;
  localparam int GATE_W = ADDR_W - BANK_AW - DEC_W;

  map_mode_e mode;
  assign mode = map_mode_e'(full_mode);

  logic [BANKS-1:0] d_sel_n, g_sel_n, nx_sel_n;
  logic d_conf, d_unm, d_alias, g_unm;
  logic nx_conf, nx_unm, nx_alias;

  memsel_direct #(.BANKS(BANKS), .HIGH_W(HIGH_W)) direct_i (
    .mem_cycle (mem_cycle),
    .sel_bits  (addr[BANK_AW +: BANKS]),
    .high_bits (addr[ADDR_W-1 -: HIGH_W]),
    .sel_n     (d_sel_n),
    .conflict  (d_conf),
    .unmapped  (d_unm),
    .alias_hit (d_alias)
  );

  memsel_gated #(.BANKS(BANKS), .DEC_W(DEC_W), .GATE_W(GATE_W)) gated_i (
    .mem_cycle (mem_cycle),
    .index     (addr[BANK_AW +: DEC_W]),
    .gate_bits (addr[ADDR_W-1 -: GATE_W]),
    .sel_n     (g_sel_n),
    .unmapped  (g_unm)
  );

  always_comb begin
    if (mode == MAP_GATED) begin
      nx_sel_n = g_sel_n;
      nx_conf  = 1'b0;
      nx_unm   = g_unm;
      nx_alias = 1'b0;
    end else begin
      nx_sel_n = d_sel_n;
      nx_conf  = d_conf;
      nx_unm   = d_unm;
      nx_alias = d_alias;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_n     <= '1;
      rw_out    <= '1;
      bank_addr <= '0;
      conflict  <= 1'b0;
      unmapped  <= 1'b0;
      alias_hit <= 1'b0;
    end else begin
      sel_n     <= nx_sel_n;
      rw_out    <= {BANKS{rw_in}};
      bank_addr <= addr[BANK_AW-1:0];
      conflict  <= nx_conf;
      unmapped  <= nx_unm;
      alias_hit <= nx_alias;
    end
  end
endmodule

// File: rtl/memsel_checker.sv
module memsel_checker #(
  parameter int ADDR_W  = 16,
  parameter int BANK_AW = 10,
  parameter int BANKS   = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [ADDR_W-1:0]  addr,
  input logic               mem_cycle,
  input logic               full_mode,
  input logic               rw_in,
  input logic [BANKS-1:0]   sel_n,
  input logic [BANKS-1:0]   rw_out,
  input logic [BANK_AW-1:0] bank_addr,
  input logic               conflict,
  input logic               unmapped,
  input logic               alias_hit
);
  // R1: outputs idle on the first clock after reset
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sel_n == '1 && !conflict && !unmapped && !alias_hit));

  // R2: I/O cycles select nothing
  p_io_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(mem_cycle)) |->
      (sel_n == '1 && !conflict && !unmapped && !alias_hit));

  // R3: direct mode follows the mid address bits
  p_direct_sel_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mem_cycle) && !$past(full_mode)) |->
      (sel_n == $past(addr[BANK_AW +: BANKS])));

  // R4: conflict only with several selects active
  p_conflict_r4: assert property (@(posedge clk) disable iff (rst)
    conflict |-> ($countones(~sel_n) >= 2));

  // R7: unmapped only when nothing is selected
  p_unmapped_r7: assert property (@(posedge clk) disable iff (rst)
    unmapped |-> (sel_n == '1));

  // R8: gated mode selects at most one bank
  p_gated_single_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(full_mode)) |->
      ($onehot0(~sel_n) && !conflict && !alias_hit));

  // R9: read/write line copied to all banks
  p_rw_copy_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (rw_out == {BANKS{$past(rw_in)}}));
endmodule

bind memsel_top memsel_checker #(.ADDR_W(ADDR_W), .BANK_AW(BANK_AW), .BANKS(BANKS)) chk_i (
  .clk(clk), .rst(rst), .addr(addr), .mem_cycle(mem_cycle), .full_mode(full_mode),
  .rw_in(rw_in), .sel_n(sel_n), .rw_out(rw_out), .bank_addr(bank_addr),
  .conflict(conflict), .unmapped(unmapped), .alias_hit(alias_hit)
);

// File: tb/memsel_top_tb.sv
module memsel_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = '0;
  logic        mem_cycle = 1'b0;
  logic        full_mode = 1'b0;
  logic        rw_in = 1'b1;
  logic [3:0]  sel_n, rw_out;
  logic [9:0]  bank_addr;
  logic        conflict, unmapped, alias_hit;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  memsel_top dut_i (
    .clk(clk), .rst(rst), .addr(addr), .mem_cycle(mem_cycle), .full_mode(full_mode),
    .rw_in(rw_in), .sel_n(sel_n), .rw_out(rw_out), .bank_addr(bank_addr),
    .conflict(conflict), .unmapped(unmapped), .alias_hit(alias_hit)
  );

  typedef struct packed {
    logic [3:0] sel;
    logic conf;
    logic unm;
    logic ali;
  } exp_t;

  function automatic exp_t model(input logic [15:0] a, input logic m, input logic f);
    exp_t e;
    int zeros;
    e = '{sel: 4'hF, conf: 1'b0, unm: 1'b0, ali: 1'b0};
    if (!m) return e;
    if (!f) begin
      e.sel = a[13:10];
      zeros = 0;
      for (int k = 0; k < 4; k++) if (!a[10+k]) zeros++;
      e.conf = (zeros >= 2);
      e.unm  = (zeros == 0);
      e.ali  = (zeros != 0) && (a[15:14] != 2'b00);
    end else begin
      if (a[15:13] == 3'b000 && a[12:10] < 3'd4) e.sel = ~(4'b0001 << a[12:10]);
      e.unm = (e.sel == 4'hF);
    end
    return e;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply_check(input logic [15:0] a, input logic m, input logic f, input logic rw);
    exp_t e;
    @(negedge clk);
    addr = a; mem_cycle = m; full_mode = f; rw_in = rw;
    @(posedge clk);
    #1;
    e = model(a, m, f);
    if (!m) begin
      chk("R2 sel", {12'h0, sel_n}, {12'h0, e.sel});
      chk("R2 flags", {13'h0, conflict, unmapped, alias_hit}, 16'h0);
    end else if (!f) begin
      chk("R3 sel", {12'h0, sel_n}, {12'h0, e.sel});
      chk("R4 conflict", {15'h0, conflict}, {15'h0, e.conf});
      chk("R5 alias", {15'h0, alias_hit}, {15'h0, e.ali});
      chk("R7 unmapped", {15'h0, unmapped}, {15'h0, e.unm});
    end else begin
      chk("R6 sel", {12'h0, sel_n}, {12'h0, e.sel});
      chk("R7 unmapped", {15'h0, unmapped}, {15'h0, e.unm});
      chk("R8 conflict/alias", {14'h0, conflict, alias_hit}, 16'h0);
    end
    chk("R9 rw", {12'h0, rw_out}, {12'h0, {4{rw}}});
    chk("R9 bank_addr", {6'h0, bank_addr}, {6'h0, a[9:0]});
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset sel", {12'h0, sel_n}, 16'h000F);
    chk("R1 reset flags", {13'h0, conflict, unmapped, alias_hit}, 16'h0);
    @(negedge clk);
    addr = 16'h0000; mem_cycle = 1'b1; full_mode = 1'b0;
    rst = 1'b0;
    @(posedge clk); #1;
    chk("R3 after reset", {12'h0, sel_n}, 16'h0000);

    // R5 mirrored pair
    apply_check(16'h3800, 1, 0, 1);
    chk("R5 bank I at 3800", {12'h0, sel_n}, 16'h000E);
    apply_check(16'hB800, 1, 0, 0);
    chk("R5 bank I at B800", {12'h0, sel_n}, 16'h000E);
    chk("R5 alias at B800", {15'h0, alias_hit}, 16'h1);
    apply_check(16'h0000, 1, 0, 1);   // R4 all four selected
    chk("R4 all low", {15'h0, conflict}, 16'h1);
    apply_check(16'h3C00, 1, 0, 1);   // R7 nothing selected in direct mode
    chk("R7 direct none", {15'h0, unmapped}, 16'h1);
    // R6 bank boundaries
    apply_check(16'h0000, 1, 1, 1);
    apply_check(16'h03FF, 1, 1, 0);
    apply_check(16'h0400, 1, 1, 1);
    apply_check(16'h0BFF, 1, 1, 1);
    apply_check(16'h0C00, 1, 1, 0);
    chk("R6 bank IV", {12'h0, sel_n}, 16'h0007);
    apply_check(16'h1000, 1, 1, 1);
    chk("R7 index 4", {15'h0, unmapped}, 16'h1);
    apply_check(16'h2000, 1, 1, 1);
    apply_check(16'h0400, 0, 1, 1);   // R2 I/O cycle
    apply_check(16'h0000, 0, 0, 1);

    // R10 one-clock latency
    apply_check(16'h0000, 1, 1, 1);
    @(negedge clk);
    addr = 16'h0C00;
    #5;
    chk("R10 unchanged before edge", {12'h0, sel_n}, 16'h000E);
    @(posedge clk); #1;
    chk("R10 updated after edge", {12'h0, sel_n}, 16'h0007);

    for (int n = 0; n < 3000; n++) begin
      logic [15:0] a;
      logic m, f, rw;
      a = 16'($urandom);
      if (($urandom % 4) == 0) a[15:13] = 3'b000;
      m = (($urandom % 8) != 0);
      f = 1'($urandom);
      rw = 1'($urandom);
      apply_check(a, m, f, rw);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule